// File: doc/BRIEF.md
# Unaligned Vector Load Decoder

This block decodes one instruction: the load of a packed-integer vector from a memory address that need not be aligned. The front end presents a window of instruction bytes with a valid strobe and a flag for 64-bit mode. The first byte in the window is the first byte of the instruction. One clock later the block returns a decoded record: the destination register index, the vector width, how the destination bits above bit 127 are treated, the addressing fields taken from ModRM, the number of SIB and displacement bytes, the total instruction length, and an invalid-opcode flag.

The block accepts two encodings. The first is a legacy form with a mandatory F2 prefix, which in 64-bit mode may carry a REX byte. The second is the VEX escape, in both its two-byte (C5) and three-byte (C4) variants. Any byte stream that is not one of these accepted forms raises the invalid-opcode flag. This includes the wrong opcode, the wrong implied prefix, the wrong opcode map and a non-memory source operand. The flag is also raised when a VEX instruction carries a non-reserved value in its unused register field. Address size is always taken as 32/64-bit, so the 16-bit ModRM forms are never produced.

Top module: `uload_dec`

## Requirements
- R1: The legacy form is F2, then an optional REX byte, then 0F, F0 and ModRM. It decodes with width 128 (`dec_wide`=0) and upper policy code 0, which means bits above 127 are preserved.
- R2: The two-byte VEX form is C5, P, F0, ModRM. P bit 7 is the inverted R, P bits 6:3 are the inverted register field, P bit 2 is L, and P bits 1:0 must be 11.
- R3: The three-byte VEX form is C4, P0, P1, F0, ModRM. P0 bit 7 is the inverted R, bit 6 is the inverted X and bit 5 is the inverted B. P0 bits 4:0 must be 00001, and any other map value is invalid. P1 bit 7 (W) is ignored. P1 bits 6:3 are the register field, P1 bit 2 is L, and P1 bits 1:0 must be 11.
- R4: In either VEX form, a raw 4-bit register field other than 1111 sets `dec_ud`.
- R5: A VEX form with L=0 gives upper policy code 1 (zero bits above 127) and `dec_wide`=0. A VEX form with L=1 gives code 2 (all 256 bits written) and `dec_wide`=1. `dec_wide` is 1 exactly when the code is 2.
- R6: `dec_dst` is {R, ModRM[5:3]} and `dec_rm` is {B, ModRM[2:0]}. In the legacy form, R is REX bit 2 and B is REX bit 0. In the VEX forms, R and B are the complements of the stored bits, and the two-byte form has B=0. Outside 64-bit mode, R and B are always 0.
- R7: A ModRM mod field of 11 (register source) sets `dec_ud`.
- R8: `dec_len` counts every byte of the instruction: the header bytes before ModRM (3 for the legacy form without REX and for C5; 4 for the legacy form with REX and for C4), then 1 for ModRM, then 1 for a SIB byte (present when r/m=100), then the displacement bytes. Mod 01 adds 1 byte and mod 10 adds 4. Mod 00 adds 4 when r/m=101, or when r/m=100 and SIB bits 2:0 are 101.
- R9: A byte stream matching no accepted form sets `dec_ud`. This covers another first byte, another opcode and a wrong implied prefix. A REX byte (40 to 4F) is accepted only in 64-bit mode.
- R10: When `dec_ud` is 1, every other record field, `dec_len` included, is 0.
- R11: `dec_valid` is `in_valid` delayed by one clock. The record belongs to the window presented in that earlier cycle. Reset clears `dec_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window holds an instruction to decode |
| in_mode64 | input | 1 | Processor is in 64-bit mode |
| in_bytes | input | WIN_BYTES*8 (128) | Instruction bytes, byte 0 in bits 7:0 |
| dec_valid | output | 1 | Record is valid |
| dec_ud | output | 1 | Invalid-opcode fault |
| dec_dst | output | 4 | Destination register index |
| dec_wide | output | 1 | 256-bit operation |
| dec_upper | output | 2 | Upper-bit policy: 0 preserve, 1 zero, 2 full write |
| dec_mod | output | 2 | ModRM mod field |
| dec_rm | output | 4 | Extended r/m field |
| dec_sib | output | 1 | SIB byte present |
| dec_disp | output | 3 | Displacement byte count |
| dec_len | output | LEN_W (5) | Total instruction length in bytes |

## Verification
Some checks run on every cycle, whatever the stimulus:
- the one-cycle valid handshake;
- the clearing of the record on a fault;
- the absence of register sources in accepted records;
- the tie between width and upper policy;
- the length range;
- the absence of extended indices outside 64-bit mode.

Other behaviour needs the bench's scenarios and its per-clock reference model. This covers which encodings count as legal, the exact length for each ModRM/SIB shape, the REX-versus-mode interaction, ignoring W, and rejecting bad maps, prefixes and register fields. The bench runs both directed windows and a seeded mix of them.

// File: rtl/uload_pkg.sv
package uload_pkg;
    localparam int REG_IDX_W = 4;
    localparam int FIELD_W   = 3;
    localparam int DISP_W    = 3;

    localparam logic [7:0] PFX_REPNE = 8'hF2;
    localparam logic [7:0] ESC_TWO   = 8'h0F;
    localparam logic [7:0] OPC_LOAD  = 8'hF0;
    localparam logic [7:0] VEX_SHORT = 8'hC5;
    localparam logic [7:0] VEX_LONG  = 8'hC4;
    localparam logic [4:0] MAP_0F    = 5'b00001;
    localparam logic [1:0] PP_F2     = 2'b11;

    typedef enum logic [1:0] {
        FORM_NONE   = 2'd0,
        FORM_LEGACY = 2'd1,
        FORM_VEX2   = 2'd2,
        FORM_VEX3   = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        UPPER_KEEP = 2'd0,
        UPPER_ZERO = 2'd1,
        UPPER_FULL = 2'd2
    } upper_e;
endpackage

// File: rtl/uload_form_detect.sv
module uload_form_detect
    import uload_pkg::*;
(
    input  logic [7:0]           b0,
    input  logic [7:0]           b1,
    input  logic [7:0]           b2,
    input  logic [7:0]           b3,
    input  logic                 mode64,
    output form_e                form,
    output logic [FIELD_W-1:0]   hdr_len,
    output logic                 r_ext,
    output logic                 b_ext,
    output logic                 l256,
    output logic                 vvvv_bad
);
    logic rex_here;

    always_comb begin
        rex_here = mode64 && (b1[7:4] == 4'h4);
        form     = FORM_NONE;
        hdr_len  = '0;
        r_ext    = 1'b0;
        b_ext    = 1'b0;
        l256     = 1'b0;
        vvvv_bad = 1'b0;
        if (b0 == PFX_REPNE) begin
            if (rex_here && b2 == ESC_TWO && b3 == OPC_LOAD) begin
                form    = FORM_LEGACY;
                hdr_len = FIELD_W'(4);
                r_ext   = b1[2];
                b_ext   = b1[0];
            end else if (b1 == ESC_TWO && b2 == OPC_LOAD) begin
                form    = FORM_LEGACY;
                hdr_len = FIELD_W'(3);
            end
        end else if (b0 == VEX_SHORT) begin
            if (b1[1:0] == PP_F2 && b2 == OPC_LOAD) begin
                form     = FORM_VEX2;
                hdr_len  = FIELD_W'(3);
                r_ext    = ~b1[7] & mode64;
                l256     = b1[2];
                vvvv_bad = (b1[6:3] != 4'hF);
            end
        end else if (b0 == VEX_LONG) begin
            // W (b2[7]) takes no part in the match
            if (b1[4:0] == MAP_0F && b2[1:0] == PP_F2 && b3 == OPC_LOAD) begin
                form     = FORM_VEX3;
                hdr_len  = FIELD_W'(4);
                r_ext    = ~b1[7] & mode64;
                b_ext    = ~b1[5] & mode64 & ~b1[6] | ~b1[5] & mode64 & b1[6];
                l256     = b2[2];
                vvvv_bad = (b2[6:3] != 4'hF);
            end
        end
    end
endmodule

// File: rtl/uload_addr_len.sv
module uload_addr_len
    import uload_pkg::*;
(
    input  logic [7:0]          modrm,
    input  logic [2:0]          sib_base,
    output logic [1:0]          mod_f,
    output logic [2:0]          reg_f,
    output logic [2:0]          rm_f,
    output logic                sib_here,
    output logic [DISP_W-1:0]   disp_len,
    output logic                reg_source
);
    always_comb begin
        mod_f      = modrm[7:6];
        reg_f      = modrm[5:3];
        rm_f       = modrm[2:0];
        reg_source = (mod_f == 2'b11);
        sib_here   = !reg_source && (rm_f == 3'b100);
        unique case (mod_f)
            2'b01:   disp_len = DISP_W'(1);
            2'b10:   disp_len = DISP_W'(4);
            2'b00: begin
                if (rm_f == 3'b101 || (sib_here && sib_base == 3'b101))
                    disp_len = DISP_W'(4);
                else
                    disp_len = '0;
            end
            default: disp_len = '0;
        endcase
    end
endmodule

// File: rtl/uload_dec.sv
module uload_dec
    import uload_pkg::*;
#(
    parameter int WIN_BYTES = 16,
    parameter int LEN_W     = $clog2(WIN_BYTES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_mode64,
    input  logic [WIN_BYTES*8-1:0]   in_bytes,
    output logic                     dec_valid,
    output logic                     dec_ud,
    output logic [REG_IDX_W-1:0]     dec_dst,
    output logic                     dec_wide,
    output logic [1:0]               dec_upper,
    output logic [1:0]               dec_mod,
    output logic [REG_IDX_W-1:0]     dec_rm,
    output logic                     dec_sib,
    output logic [DISP_W-1:0]        dec_disp,
    output logic [LEN_W-1:0]         dec_len
);
    localparam int IDX_W = $clog2(WIN_BYTES);

    typedef struct packed {
        logic                  vld;
        logic                  ud;
        logic [REG_IDX_W-1:0]  dst;
        logic                  wide;
        upper_e                upper;
        logic [1:0]            mod;
        logic [REG_IDX_W-1:0]  rm;
        logic                  sib;
        logic [DISP_W-1:0]     disp;
        logic [LEN_W-1:0]      len;
    } rec_t;

    logic [7:0] win_b [WIN_BYTES];

    for (genvar gi = 0; gi < WIN_BYTES; gi++) begin : g_unpack
        assign win_b[gi] = in_bytes[8*gi +: 8];
    end

    form_e              form;
    logic [FIELD_W-1:0] hdr_len;
    logic               r_ext, b_ext, l256, vvvv_bad;

    uload_form_detect u_form (
        .b0       (win_b[0]),
        .b1       (win_b[1]),
        .b2       (win_b[2]),
        .b3       (win_b[3]),
        .mode64   (in_mode64),
        .form     (form),
        .hdr_len  (hdr_len),
        .r_ext    (r_ext),
        .b_ext    (b_ext),
        .l256     (l256),
        .vvvv_bad (vvvv_bad)
    );

    logic [IDX_W-1:0]  mrm_idx, sib_idx;
    logic [7:0]        modrm_byte;
    logic [2:0]        sib_base;
    logic [1:0]        mod_f;
    logic [2:0]        reg_f, rm_f;
    logic              sib_here, reg_source;
    logic [DISP_W-1:0] disp_len;

    assign mrm_idx    = IDX_W'(hdr_len);
    assign sib_idx    = mrm_idx + IDX_W'(1);
    assign modrm_byte = win_b[mrm_idx];
    assign sib_base   = win_b[sib_idx][2:0];

    uload_addr_len u_alen (
        .modrm      (modrm_byte),
        .sib_base   (sib_base),
        .mod_f      (mod_f),
        .reg_f      (reg_f),
        .rm_f       (rm_f),
        .sib_here   (sib_here),
        .disp_len   (disp_len),
        .reg_source (reg_source)
    );

    rec_t rec_d, rec_q;
    logic fault;

    always_comb begin
        rec_d     = '0;
        rec_d.vld = in_valid;
        fault     = (form == FORM_NONE) || vvvv_bad || reg_source;
        if (in_valid) begin
            if (fault) begin
                rec_d.ud = 1'b1;
            end else begin
                rec_d.dst  = {r_ext, reg_f};
                rec_d.rm   = {b_ext, rm_f};
                rec_d.mod  = mod_f;
                rec_d.sib  = sib_here;
                rec_d.disp = disp_len;
                rec_d.len  = LEN_W'(hdr_len) + LEN_W'(1)
                           + LEN_W'(sib_here) + LEN_W'(disp_len);
                if (form == FORM_LEGACY) begin
                    rec_d.upper = UPPER_KEEP;
                    rec_d.wide  = 1'b0;
                end else begin
                    rec_d.upper = l256 ? UPPER_FULL : UPPER_ZERO;
                    rec_d.wide  = l256;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign dec_valid = rec_q.vld;
    assign dec_ud    = rec_q.ud;
    assign dec_dst   = rec_q.dst;
    assign dec_wide  = rec_q.wide;
    assign dec_upper = rec_q.upper;
    assign dec_mod   = rec_q.mod;
    assign dec_rm    = rec_q.rm;
    assign dec_sib   = rec_q.sib;
    assign dec_disp  = rec_q.disp;
    assign dec_len   = rec_q.len;

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> dec_valid);                                   // R11
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !dec_valid);                                 // R11
    AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_ud) |-> (dec_len == '0 && dec_dst == '0 && dec_upper == 2'd0 && !dec_sib)); // R10
    AST_NO_REG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_mod != 2'b11));                         // R7
    AST_WIDE_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_ud) |-> (dec_wide == (dec_upper == 2'd2))); // R5
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_ud) |-> (dec_len >= LEN_W'(4) && dec_len <= LEN_W'(10))); // R8
    AST_NO_EXT_LEGACY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !$past(in_mode64)) |-> (!dec_dst[REG_IDX_W-1] && !dec_rm[REG_IDX_W-1])); // R6
endmodule

// File: tb/uload_dec_bench.sv
module uload_dec_bench;
    localparam int WB = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_mode64 = 1'b0;
    logic [WB*8-1:0] in_bytes = '0;
    logic            dec_valid, dec_ud, dec_wide, dec_sib;
    logic [3:0]      dec_dst, dec_rm;
    logic [1:0]      dec_upper, dec_mod;
    logic [2:0]      dec_disp;
    logic [4:0]      dec_len;

    uload_dec u_uload_dec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode64(in_mode64),
        .in_bytes(in_bytes), .dec_valid(dec_valid), .dec_ud(dec_ud),
        .dec_dst(dec_dst), .dec_wide(dec_wide), .dec_upper(dec_upper),
        .dec_mod(dec_mod), .dec_rm(dec_rm), .dec_sib(dec_sib),
        .dec_disp(dec_disp), .dec_len(dec_len)
    );

    always #4 clk = ~clk;

    typedef struct {
        bit vld; bit ud; int dst; bit wide; int upper;
        int mod; int rm; bit sib; int disp; int len;
        string tag;
    } exp_t;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t pend;

    function automatic exp_t model(logic [WB*8-1:0] w, bit m64, bit v, string tag);
        exp_t e;
        int b[WB];
        int p = 0;
        bit ok = 0, vbad = 0;
        int r = 0, bx = 0, up = 0;
        bit wd = 0;
        int mrm, md, rmv, dsp;
        bit sb;
        for (int i = 0; i < WB; i++) b[i] = int'(w[8*i +: 8]);
        e = '{vld: v, ud: 0, dst: 0, wide: 0, upper: 0, mod: 0, rm: 0,
              sib: 0, disp: 0, len: 0, tag: tag};
        if (!v) return e;
        if (b[0] == 'hF2) begin
            p = 1;
            if (m64 && b[1] >= 'h40 && b[1] <= 'h4F) begin
                r = (b[1] >> 2) & 1; bx = b[1] & 1; p = 2;
            end
            if (b[p] == 'h0F && b[p+1] == 'hF0) begin ok = 1; p = p + 2; up = 0; end
        end else if (b[0] == 'hC5) begin
            if ((b[1] & 3) == 3 && b[2] == 'hF0) begin
                ok = 1; p = 3;
                r = m64 ? (((b[1] >> 7) & 1) ^ 1) : 0;
                vbad = ((b[1] >> 3) & 'hF) != 'hF;
                wd = (b[1] >> 2) & 1; up = wd ? 2 : 1;
            end
        end else if (b[0] == 'hC4) begin
            if ((b[1] & 'h1F) == 1 && (b[2] & 3) == 3 && b[3] == 'hF0) begin
                ok = 1; p = 4;
                r  = m64 ? (((b[1] >> 7) & 1) ^ 1) : 0;
                bx = m64 ? (((b[1] >> 5) & 1) ^ 1) : 0;
                vbad = ((b[2] >> 3) & 'hF) != 'hF;
                wd = (b[2] >> 2) & 1; up = wd ? 2 : 1;
            end
        end
        mrm = (p < WB) ? b[p] : 0;
        md  = mrm >> 6;
        rmv = mrm & 7;
        sb  = (md != 3) && (rmv == 4);
        dsp = (md == 1) ? 1 : (md == 2) ? 4 : 0;
        if (md == 0 && rmv == 5) dsp = 4;
        if (md == 0 && sb && p + 1 < WB && (b[p+1] & 7) == 5) dsp = 4;
        if (!ok || vbad || md == 3) begin
            e.ud = 1;
            return e;
        end
        e.dst = r * 8 + ((mrm >> 3) & 7);
        e.rm = bx * 8 + rmv;
        e.mod = md; e.sib = sb; e.disp = dsp;
        e.len = p + 1 + int'(sb) + dsp;
        e.wide = wd; e.upper = up;
        return e;
    endfunction

    task automatic chk(string req, string fld, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, fld, act, exp);
        end
    endtask

    task automatic compare();
        string rq = pend.ud ? "R10" : "R6";
        chk("R11", "valid", int'(dec_valid), int'(pend.vld));
        if (!pend.vld) return;
        chk(pend.tag, "ud", int'(dec_ud), int'(pend.ud));
        chk(rq, "dst", int'(dec_dst), pend.dst);
        chk(rq, "rm", int'(dec_rm), pend.rm);
        chk(rq, "mod", int'(dec_mod), pend.mod);
        chk(pend.ud ? "R10" : "R5", "upper", int'(dec_upper), pend.upper);
        chk(pend.ud ? "R10" : "R5", "wide", int'(dec_wide), int'(pend.wide));
        chk(pend.ud ? "R10" : "R8", "sib", int'(dec_sib), int'(pend.sib));
        chk(pend.ud ? "R10" : "R8", "disp", int'(dec_disp), pend.disp);
        chk(pend.ud ? "R10" : "R8", "len", int'(dec_len), pend.len);
    endtask

    // bytes written first-byte-leftmost in s; the unused tail is filled with AA
    function automatic logic [WB*8-1:0] pk(logic [79:0] s, int n);
        logic [WB*8-1:0] w = '0;
        for (int i = 0; i < WB; i++)
            w[8*i +: 8] = (i < n) ? s[79-8*i -: 8] : 8'hAA;
        return w;
    endfunction

    task automatic step(bit v, bit m64, logic [WB*8-1:0] w, string tag);
        @(negedge clk);
        compare();
        in_valid = v; in_mode64 = m64; in_bytes = w;
        pend = model(w, m64, v, tag);
    endtask

    task automatic put(bit m64, logic [79:0] s, int n, string tag);
        step(1'b1, m64, pk(s, n), tag);
    endtask

    function automatic logic [79:0] rnd_inst(int unsigned x);
        logic [7:0] mrm = 8'(x >> 8);
        logic [7:0] sib = 8'(x >> 16);
        logic [7:0] p1  = 8'(x >> 24);
        case (x % 5)
            0: return {8'hF2, 8'h0F, 8'hF0, mrm, sib, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
            1: return {8'hF2, 8'h40 | (p1 & 8'h0F), 8'h0F, 8'hF0, mrm, sib, 8'h11, 8'h22, 8'h33, 8'h44};
            2: return {8'hC5, p1 | 8'h03, 8'hF0, mrm, sib, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
            3: return {8'hC4, (p1 & 8'hE0) | 8'h01, (sib & 8'h84) | 8'h7B, 8'hF0, mrm, sib, 8'h11, 8'h22, 8'h33, 8'h44};
            default: return {8'(x), p1, sib, mrm, 8'hF0, 8'h0F, 8'h11, 8'h22, 8'h33, 8'h44};
        endcase
    endfunction

    initial begin
        pend = model('0, 1'b0, 1'b0, "R11");
        repeat (3) @(negedge clk);
        // reset state: R11
        chk("R11", "reset valid", int'(dec_valid), 0);
        chk("R10", "reset len", int'(dec_len), 0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, '0, "R11");
        put(0, 80'hF2_0F_F0_08_00_00_00_00_00_00, 4, "R1");
        put(0, 80'hF2_0F_F0_45_10_00_00_00_00_00, 5, "R1");      // R8 disp8
        put(1, 80'hF2_4D_0F_F0_8C_24_11_22_33_44, 10, "R6");     // REX.R/B, SIB, disp32
        put(0, 80'hF2_4D_0F_F0_8C_24_11_22_33_44, 10, "R9");     // REX outside 64-bit
        put(1, 80'hF2_0F_F0_84_25_01_02_03_04_00, 9, "R8");      // SIB with disp32 (mod10)
        put(0, 80'hC5_FB_F0_00_00_00_00_00_00_00, 4, "R2");      // VEX.128
        put(1, 80'hC5_7F_F0_18_00_00_00_00_00_00, 4, "R5");      // VEX.256, R ext
        put(0, 80'hC5_7F_F0_18_00_00_00_00_00_00, 4, "R6");      // R ignored outside 64
        put(1, 80'hC5_F3_F0_00_00_00_00_00_00_00, 4, "R4");      // bad vvvv
        put(1, 80'hC5_FA_F0_00_00_00_00_00_00_00, 4, "R9");      // wrong implied prefix
        put(1, 80'hC4_41_FF_F0_04_25_01_02_03_04, 10, "R3");     // W=1, L=1, B ext, SIB base101
        put(1, 80'hC4_41_7F_F0_04_25_01_02_03_04, 10, "R3");     // W=0 same result
        put(0, 80'hC4_E1_7B_F0_05_01_02_03_04_00, 9, "R8");      // mod00 rm101
        put(1, 80'hC4_E2_7B_F0_00_00_00_00_00_00, 5, "R3");      // bad map
        put(1, 80'hC4_E1_73_F0_00_00_00_00_00_00, 5, "R4");      // bad vvvv
        put(1, 80'hF2_0F_F0_C1_00_00_00_00_00_00, 4, "R7");      // register source
        put(1, 80'hC5_FB_F0_C0_00_00_00_00_00_00, 4, "R7");
        put(1, 80'hF3_0F_F0_00_00_00_00_00_00_00, 4, "R9");      // other prefix
        put(1, 80'hF2_0F_6F_00_00_00_00_00_00_00, 4, "R9");      // other opcode
        put(1, 80'hF2_0F_F0_04_24_00_00_00_00_00, 5, "R8");      // SIB, no disp
        step(1'b0, 1'b1, pk(80'hC5_FB_F0_00_00_00_00_00_00_00, 4), "R11");
        step(1'b0, 1'b0, '0, "R11");
        begin
            int unsigned seed = 32'h1234_5678;
            for (int k = 0; k < 300; k++) begin
                seed = seed * 32'd1664525 + 32'd1013904223;
                step(seed[3:0] != 4'h0, seed[4], pk(rnd_inst(seed ^ (seed >> 13)), 10), "R9");
            end
        end
        // reset while valid is high: R11
        @(negedge clk);
        compare();
        in_valid = 1'b1;
        in_bytes = pk(80'hF2_0F_F0_08_00_00_00_00_00_00, 4);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11", "valid under reset", int'(dec_valid), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "valid after reset", int'(dec_valid), 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule